// File: doc/BRIEF.md
# Password-Unlocked Flash Lock Register

This block holds the write-protection state for one flash array: a single lock bit for the test/shadow region and a lock bit for each low/mid sector. Software reaches it through a simple 32-bit register port with an address, a write strobe, write data and registered read data. The lock bits cannot be changed by an ordinary write. Software must first write a fixed 32-bit key to a separate enable address. That sets a read-only enable flag, and the flag stays set until the next reset.

At reset the lock bits do not come from a constant. They load from a preload input that carries the non-volatile setting. An all-ones (erased) preload therefore brings the array up fully locked. The block also follows program/erase activity. An interlock pulse marks the start of an operation and a done pulse marks its end. The test/shadow lock bit is frozen from the interlock pulse until done, and also for as long as a suspend input is high. The block turns the lock state into permit signals for the program/erase gating logic.

Top module: `flash_lock_reg`

## Requirements
- R1: While `rst_ni` is low, the enable flag and the operation-busy state clear. `ts_lock_o` takes `preload_i[16]` and `sect_lock_o` takes `preload_i[15:0]`. `reg_rdata_o` reads 0.
- R2: A write of exactly 0xA1A11111 to address `EN_ADDR` (default 0x00) sets the enable flag. The flag reads back at data bit 31 of that address, and every other bit there reads 0. A write of any other value to that address changes nothing. Only reset clears the flag.
- R3: While the enable flag is 0, writes to address `LOCK_ADDR` (default 0x04) leave every lock bit unchanged.
- R4: In the lock register, data bit 20 is the test/shadow lock and data bit k (0..15) is the lock for sector k. All other bits ignore writes and read 0. Any unmapped address reads 0.
- R5: An interlock pulse marks an operation as busy, and a done pulse ends it. When both arrive in the same cycle, done wins and the block is not busy afterwards. While busy, and in the cycle of the interlock pulse itself, writes leave the test/shadow lock unchanged.
- R6: While `suspend_i` is high, writes leave the test/shadow lock unchanged.
- R7: Once the enable flag is set, the sector lock bits accept writes even while an operation is busy or suspended.
- R8: `ts_prog_ok_o` is 1 only when the test/shadow lock and `sec_lock_i` are both 0. `ts_erase_ok_o` is always 0. `sect_ok_o[k]` is the inverse of sector lock k.
- R9: A write changes the lock outputs on the clock edge that samples the strobe. `reg_rdata_o` is registered: it shows the value at the address presented in a cycle after the following edge, so a read in the cycle right after a write returns the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_addr_i | input | 8 | Register address |
| reg_we_i | input | 1 | Write strobe |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Registered read data |
| preload_i | input | 17 | Reset value for the locks: bit 16 is test/shadow, bits 15:0 are the sectors |
| interlock_i | input | 1 | Pulse: a program/erase interlock write was accepted |
| done_i | input | 1 | Pulse: the operation has completed |
| suspend_i | input | 1 | High while a high-voltage operation is suspended |
| sec_lock_i | input | 1 | Secondary lock for test/shadow programming |
| ts_lock_o | output | 1 | Test/shadow lock state |
| sect_lock_o | output | 16 | Sector lock states |
| ts_prog_ok_o | output | 1 | Test/shadow program permit |
| ts_erase_ok_o | output | 1 | Test/shadow erase permit (always 0) |
| sect_ok_o | output | 16 | Per-sector program/erase permit |

## Verification
Two pairs of events can land in the same cycle. The first pair is an interlock pulse together with a done pulse. The second is an interlock pulse together with a lock-register write. The bench drives each pair on the same clock edge. It then writes the test/shadow bit in the next cycle: the write must succeed after interlock plus done, and must be ignored when it coincided with the interlock. A behavioural model that gives done priority judges both cases, and outputs and read data are compared against it on every clock.

// File: rtl/flash_lock_pkg.sv
package flash_lock_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned TS_BIT = 20;
  localparam int unsigned EN_BIT = 31;
  localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'hA1A1_1111;
endpackage

// File: rtl/fl_unlock.sv
module fl_unlock
  import flash_lock_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] EN_ADDR = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              en_o
);
  logic en_q;
  logic key_hit;

  assign key_hit = we_i && (addr_i == EN_ADDR) && (wdata_i == UNLOCK_KEY);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      en_q <= 1'b0;
    else if (key_hit) en_q <= 1'b1;
  end

  assign en_o = en_q;

  // R2: sticky once set
  p_en_sticky_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q |=> en_q);
  // R2: only a key write at the enable address sets it
  p_en_cause_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(en_q) |-> $past(we_i && addr_i == EN_ADDR && wdata_i == UNLOCK_KEY));
endmodule

// File: rtl/fl_op_track.sv
module fl_op_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic interlock_i,
  input  logic done_i,
  input  logic suspend_i,
  output logic ts_frozen_o
);
  logic busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          busy_q <= 1'b0;
    else if (done_i)      busy_q <= 1'b0;
    else if (interlock_i) busy_q <= 1'b1;
  end

  // frozen already in the cycle the interlock arrives
  assign ts_frozen_o = busy_q | interlock_i | suspend_i;

  p_done_prio_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !busy_q);
  p_busy_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (interlock_i && !done_i) |=> busy_q);
endmodule

// File: rtl/fl_lock_store.sv
module fl_lock_store
  import flash_lock_pkg::*;
#(
  parameter int unsigned NUM_SECT = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic                ts_frozen_i,
  input  logic                wr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  input  logic [NUM_SECT:0]   preload_i,
  output logic                ts_o,
  output logic [NUM_SECT-1:0] sect_o
);
  logic                ts_q;
  logic [NUM_SECT-1:0] sect_q;
  logic                wr_ok;

  assign wr_ok = wr_i & en_i;

  // reset loads the non-volatile preload, not a constant
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    ts_q <= preload_i[NUM_SECT];
    else if (wr_ok && !ts_frozen_i) ts_q <= wdata_i[TS_BIT];
  end

  for (genvar k = 0; k < NUM_SECT; k++) begin : g_sect
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    sect_q[k] <= preload_i[k];
      else if (wr_ok) sect_q[k] <= wdata_i[k];
    end
  end

  assign ts_o   = ts_q;
  assign sect_o = sect_q;

  p_locked_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> ($stable(sect_q) && $stable(ts_q)));
  p_ts_frozen_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ts_frozen_i |=> $stable(ts_q));
endmodule

// File: rtl/flash_lock_reg.sv
module flash_lock_reg
  import flash_lock_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned NUM_SECT  = 16,
  parameter logic [ADDR_W-1:0] EN_ADDR   = 8'h00,
  parameter logic [ADDR_W-1:0] LOCK_ADDR = 8'h04
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   reg_addr_i,
  input  logic                reg_we_i,
  input  logic [DATA_W-1:0]   reg_wdata_i,
  output logic [DATA_W-1:0]   reg_rdata_o,
  input  logic [NUM_SECT:0]   preload_i,
  input  logic                interlock_i,
  input  logic                done_i,
  input  logic                suspend_i,
  input  logic                sec_lock_i,
  output logic                ts_lock_o,
  output logic [NUM_SECT-1:0] sect_lock_o,
  output logic                ts_prog_ok_o,
  output logic                ts_erase_ok_o,
  output logic [NUM_SECT-1:0] sect_ok_o
);
  logic                en;
  logic                ts_frozen;
  logic                ts;
  logic [NUM_SECT-1:0] sect;
  logic                lock_wr;
  logic [DATA_W-1:0]   rd_next, rdata_q;

  assign lock_wr = reg_we_i && (reg_addr_i == LOCK_ADDR);

  fl_unlock #(.ADDR_W(ADDR_W), .EN_ADDR(EN_ADDR)) u_unlock (
    .clk_i, .rst_ni, .we_i(reg_we_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .en_o(en)
  );

  fl_op_track u_track (
    .clk_i, .rst_ni, .interlock_i, .done_i, .suspend_i,
    .ts_frozen_o(ts_frozen)
  );

  fl_lock_store #(.NUM_SECT(NUM_SECT)) u_store (
    .clk_i, .rst_ni, .en_i(en), .ts_frozen_i(ts_frozen), .wr_i(lock_wr),
    .wdata_i(reg_wdata_i), .preload_i, .ts_o(ts), .sect_o(sect)
  );

  always_comb begin
    rd_next = '0;
    if (reg_addr_i == EN_ADDR) begin
      rd_next[EN_BIT] = en;
    end else if (reg_addr_i == LOCK_ADDR) begin
      rd_next[TS_BIT]       = ts;
      rd_next[NUM_SECT-1:0] = sect;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= rd_next;
  end

  assign reg_rdata_o   = rdata_q;
  assign ts_lock_o     = ts;
  assign sect_lock_o   = sect;
  assign ts_prog_ok_o  = ~ts & ~sec_lock_i;
  assign ts_erase_ok_o = 1'b0;  // test region erase is never allowed
  assign sect_ok_o     = ~sect;

  // R9: lock outputs move only on a lock-address write
  p_lock_only_by_write_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lock_wr |=> ($stable(ts_lock_o) && $stable(sect_lock_o)));
endmodule

// File: tb/flash_lock_reg_test.sv
`timescale 1ns/1ps
module flash_lock_reg_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [16:0] preload = 17'h1FFFF;
  logic        il = 1'b0, done = 1'b0, susp = 1'b0, sec = 1'b0;
  logic        ts_lock, ts_pok, ts_eok;
  logic [15:0] sect_lock, sect_ok;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // behavioural reference state
  bit          m_en, m_busy, m_ts;
  bit [15:0]   m_sect;
  bit [31:0]   m_rd;

  always #5 clk = ~clk;

  flash_lock_reg uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(addr), .reg_we_i(we),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .preload_i(preload),
    .interlock_i(il), .done_i(done), .suspend_i(susp), .sec_lock_i(sec),
    .ts_lock_o(ts_lock), .sect_lock_o(sect_lock), .ts_prog_ok_o(ts_pok),
    .ts_erase_ok_o(ts_eok), .sect_ok_o(sect_ok)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_busy = 0; m_rd = 0;
      m_ts = preload[16]; m_sect = preload[15:0];
    end else begin
      bit [31:0] nrd;
      nrd = 0;
      if (addr == 8'h00) nrd[31] = m_en;
      else if (addr == 8'h04) begin nrd[20] = m_ts; nrd[15:0] = m_sect; end
      if (we && addr == 8'h04 && m_en) begin
        m_sect = wdata[15:0];
        if (!(m_busy || il || susp)) m_ts = wdata[20];
      end
      if (we && addr == 8'h00 && wdata == 32'hA1A11111) m_en = 1;
      if (done) m_busy = 0; else if (il) m_busy = 1;
      m_rd = nrd;
    end
  end

  always @(negedge clk) if (rst_n && !finished) begin
    chk("R9 rdata", rdata, m_rd);
    chk("R5 ts_lock", {31'b0, ts_lock}, {31'b0, m_ts});
    chk("R3 sect_lock", {16'b0, sect_lock}, {16'b0, m_sect});
    chk("R8 ts_prog_ok", {31'b0, ts_pok}, {31'b0, ~m_ts & ~sec});
    chk("R8 sect_ok", {16'b0, sect_ok}, {16'b0, ~m_sect});
    chk("R8 ts_erase_ok", {31'b0, ts_eok}, 32'b0);
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd_chk(logic [7:0] a, logic [31:0] exp, string tag);
    @(negedge clk); addr = a; we = 1'b0;
    @(negedge clk); chk(tag, rdata, exp);
  endtask

  task automatic do_reset(logic [16:0] pl);
    @(negedge clk); preload = pl; #1 rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 rdata in reset", rdata, 32'h0);
    chk("R1 locks in reset", {15'b0, ts_lock, sect_lock}, {15'b0, pl});
    rst_n = 1'b1;
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      failures++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    do_reset(17'h1FFFF);
    rd_chk(8'h04, 32'h0010_FFFF, "R1 erased preload locked");
    rd_chk(8'h00, 32'h0, "R1 enable clear");
    wr(8'h04, 32'h0);
    rd_chk(8'h04, 32'h0010_FFFF, "R3 locked write ignored");
    wr(8'h00, 32'h1234_5678);
    rd_chk(8'h00, 32'h0, "R2 wrong key");
    wr(8'h00, 32'hA1A1_1111);
    rd_chk(8'h00, 32'h8000_0000, "R2 key sets enable");
    wr(8'h00, 32'h0);
    rd_chk(8'h00, 32'h8000_0000, "R2 enable sticky");
    rd_chk(8'h08, 32'h0, "R4 unmapped reads 0");
    wr(8'h04, 32'hFFEF_A5A5);
    rd_chk(8'h04, 32'h0000_A5A5, "R4 reserved bits read 0");
    // R9: read right after write sees new data
    @(negedge clk); addr = 8'h04; wdata = 32'h0010_0000; we = 1'b1;
    @(negedge clk); we = 1'b0;
    @(negedge clk); chk("R9 read after write", rdata, 32'h0010_0000);
    wr(8'h04, 32'h0);
    sec = 1'b1; @(negedge clk);
    chk("R8 sec lock blocks prog", {31'b0, ts_pok}, 32'h0);
    sec = 1'b0; @(negedge clk);
    chk("R8 prog permitted", {31'b0, ts_pok}, 32'h1);
    // R5: interlock then write while busy
    @(negedge clk); il = 1'b1; @(negedge clk); il = 1'b0;
    wr(8'h04, 32'h0010_FFFF);
    rd_chk(8'h04, 32'h0000_FFFF, "R5 R7 ts frozen busy sector written");
    @(negedge clk); done = 1'b1; @(negedge clk); done = 1'b0;
    wr(8'h04, 32'h0010_0001);
    rd_chk(8'h04, 32'h0010_0001, "R5 writable after done");
    // R5: write coincident with interlock pulse
    @(negedge clk); il = 1'b1; addr = 8'h04; wdata = 32'h0000_0002; we = 1'b1;
    @(negedge clk); il = 1'b0; we = 1'b0;
    rd_chk(8'h04, 32'h0010_0002, "R5 ts frozen on interlock cycle");
    // R5: interlock and done together, done wins
    @(negedge clk); il = 1'b1; done = 1'b1;
    @(negedge clk); il = 1'b0; done = 1'b0;
    wr(8'h04, 32'h0000_0003);
    rd_chk(8'h04, 32'h0000_0003, "R5 done priority");
    // R6: suspend
    susp = 1'b1;
    wr(8'h04, 32'h0010_0004);
    rd_chk(8'h04, 32'h0000_0004, "R6 R7 ts frozen suspended");
    susp = 1'b0;
    wr(8'h04, 32'h0010_0004);
    rd_chk(8'h04, 32'h0010_0004, "R6 writable after suspend");
    do_reset(17'h0A5A5);
    rd_chk(8'h00, 32'h0, "R1 reset clears enable");
    rd_chk(8'h04, 32'h0000_A5A5, "R1 preload value");
    wr(8'h04, 32'h0010_FFFF);
    rd_chk(8'h04, 32'h0000_A5A5, "R3 locked after reset");
    repeat (3) @(negedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule